// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a virtual address into a physical address by walking a four-level radix translation table held in memory. A requester presents a 64-bit virtual address with an access kind (instruction fetch, data read or data write). The top bits of the address choose between a lower-half and an upper-half root table, and the walker then fetches up to four 64-bit descriptors over a simple request/response memory port. Each level consumes nine address bits, starting at bits 47:39.

Every descriptor is classified by its level. Table descriptors point to the next table and may add restrictions that stay in force for the rest of the walk. Block descriptors end the walk early at the middle levels, and page descriptors end it at the last level. The walk finishes with a one-cycle completion pulse. That pulse carries either a physical address, the gathered restrictions and the final descriptor, or a fault kind and a cause code. Checking the gathered rights against the access is left to a separate stage. Only one walk is handled at a time.

Top module: `pt_walker`

## Requirements
- R1: When bits 63:48 of the request address are all zero, the first descriptor read uses `rootBase0` bits 47:12 as the table base. When they are all one, it uses `rootBase1` bits 47:12.
- R2: Any other pattern in bits 63:48 ends the walk one cycle after the request, with no memory read. It reports a fault and a cause equal to the access cause, and it leaves `faultStatus` unchanged.
- R3: The descriptor read at level L (L = 0..3) goes to address {table base bits 47:12, VA[47-9L : 39-9L], 3'b000}. For level 0 the base is the root. For later levels it is bits 47:12 of the previous table descriptor.
- R4: A descriptor whose low two bits are 00 is invalid. The walk stops at that level with a fault, the cause equal to the access cause, and `faultStatus` set to the level number.
- R5: Level 0 accepts only type 11, which is a table. Low bits 01 at levels 1 and 2 mark a block, and 11 marks a table. At level 3, 11 marks a page. Every other combination, including 01 at level 0 or level 3 and 10 at any level, is invalid and handled as in R4.
- R6: A block or page descriptor whose bit 10 is clear faults with cause 0x10 ORed with the access cause. It sets `faultStatus` to the level.
- R7: A block or page at level L with bit 10 set completes without fault (`faultType` 0, `faultCause` 0). With K = 48 - 9(L+1), `resPaddr` is the descriptor's bits 47:K joined with VA bits K-1:0, and `resDesc` is the descriptor.
- R8: Each table descriptor ORs restrictions into the result from its bits 63:59. Bit 59 sets restriction bit 0 (kernel no-execute) and bit 60 sets bit 1 (user no-execute). Field 62:61 equal to 1 sets bit 4 (no user access), equal to 2 sets bit 3 (no writes), and equal to 3 sets bit 2 (no user read/write). `resRestrict` is the OR over all table levels of the walk.
- R9: Access codes are 0 fetch, 1 read and 2 write. A fetch fault reports `faultType` 1 (instruction) with access cause 0x00. A read or write fault reports `faultType` 2 (data) with access cause 0x01 or 0x02.
- R10: Only one walk runs at a time. `busy` is high from the cycle after an accepted request until the done pulse ends. Requests made while busy are ignored, and `doneValid` lasts exactly one cycle per walk.
- R11: A descriptor request stays asserted, with its address unchanged, until `memReqReady` is seen. The response is taken when `memRspValid` is high.
- R12: After reset, `busy`, `memReqValid` and `doneValid` are low, and `faultType` and `faultStatus` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rootBase0 | input | 64 | Lower-half root table pointer (bits 47:12 used) |
| rootBase1 | input | 64 | Upper-half root table pointer (bits 47:12 used) |
| reqValid | input | 1 | Start a walk (taken only when not busy) |
| reqVaddr | input | 64 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 48 | Descriptor byte address |
| memRspValid | input | 1 | Descriptor data valid |
| memRspData | input | 64 | Descriptor data |
| doneValid | output | 1 | One-cycle completion pulse |
| faultType | output | 2 | 0 none, 1 instruction fault, 2 data fault |
| faultCause | output | 8 | Fault cause code |
| faultStatus | output | 3 | Level of the last descriptor fault |
| resPaddr | output | 48 | Translated physical address |
| resRestrict | output | 5 | Restrictions gathered from table descriptors |
| resDesc | output | 64 | Final block or page descriptor |

## Verification
A wrong level counter or table base shows at once in the address of the next descriptor request, so the bench compares the first and last request addresses of every walk. Errors in the restriction accumulator or in the leaf address split stay hidden until the done pulse. The bench therefore sweeps every value of the table attribute field at two levels and every leaf level in both halves of the address space. A fault-path error shows as a wrong cause or status on the done pulse, or as a wrong number of memory reads counted for that walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_READ  = 2'd1;
  localparam logic [1:0] ACC_WRITE = 2'd2;
  localparam logic [1:0] ACC_PROBE = 2'd3;

  localparam logic [1:0] EXC_NONE  = 2'd0;
  localparam logic [1:0] EXC_INSTR = 2'd1;
  localparam logic [1:0] EXC_DATA  = 2'd2;

  localparam int RESTRICT_W = 5;
  localparam int STATUS_W   = 3;

  typedef enum logic [1:0] {
    DK_BAD,
    DK_NEXT,
    DK_LEAF,
    DK_NOAF
  } descKind_e;

  typedef struct packed {
    logic load;
    logic rootFault;
    logic advance;
    logic leafHit;
    logic descFault;
  } walkStrobe_t;

  function automatic logic isFetchKind(logic [1:0] acc);
    return (acc == ACC_FETCH) || (acc == ACC_PROBE);
  endfunction

  function automatic logic [1:0] excFor(logic [1:0] acc);
    return isFetchKind(acc) ? EXC_INSTR : EXC_DATA;
  endfunction

  function automatic logic [7:0] causeFor(logic [1:0] acc, logic noAccessFlag);
    logic [1:0] base;
    base = isFetchKind(acc) ? 2'b00 : acc;
    return {3'b000, noAccessFlag, 2'b00, base};
  endfunction

  // attr is descriptor bits 63:59
  function automatic logic [RESTRICT_W-1:0] tableRestrict(logic [4:0] attr);
    logic [RESTRICT_W-1:0] r;
    r    = '0;
    r[0] = attr[0];
    r[1] = attr[1];
    r[4] = (attr[3:2] == 2'd1);
    r[3] = (attr[3:2] == 2'd2);
    r[2] = (attr[3:2] == 2'd3);
    return r;
  endfunction

endpackage

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import ptw_pkg::*;
#(
  parameter int VA_IN_W     = 64,
  parameter int VA_W        = 48,
  parameter int PA_W        = 48,
  parameter int IDX_W       = 9,
  parameter int LEVELS      = 4,
  parameter int PAGE_SHIFT  = 12,
  parameter int DESC_W      = 64,
  parameter int REGION_BITS = 16,
  parameter int AF_BIT      = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkStrobe_t           strobe,
  input  logic [VA_IN_W-1:0]    reqVaddr,
  input  logic [1:0]            reqAccess,
  input  logic [VA_IN_W-1:0]    rootBase0,
  input  logic [VA_IN_W-1:0]    rootBase1,
  input  logic [DESC_W-1:0]     memRspData,
  output logic                  regionOk,
  output descKind_e             rspKind,
  output logic [PA_W-1:0]       memReqAddr,
  output logic [1:0]            faultType,
  output logic [7:0]            faultCause,
  output logic [STATUS_W-1:0]   faultStatus,
  output logic [PA_W-1:0]       resPaddr,
  output logic [RESTRICT_W-1:0] resRestrict,
  output logic [DESC_W-1:0]     resDesc
);

  localparam int LVL_W       = $clog2(LEVELS);
  localparam int BASE_W      = PA_W - PAGE_SHIFT;
  localparam int ENTRY_SHIFT = $clog2(DESC_W / 8);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  logic [VA_W-1:0]       vaReg;
  logic [1:0]            accReg;
  logic [BASE_W-1:0]     baseReg;
  logic [LVL_W-1:0]      levelReg;
  logic [RESTRICT_W-1:0] restrReg;

  // region decode on the incoming request
  logic [REGION_BITS-1:0] topBits;
  logic lowRegion, highRegion;
  assign topBits    = reqVaddr[VA_IN_W-1 -: REGION_BITS];
  assign lowRegion  = (topBits == '0);
  assign highRegion = (&topBits);
  assign regionOk   = lowRegion | highRegion;

  logic unusedRootBits;
  assign unusedRootBits = ^{rootBase0[VA_IN_W-1:PA_W], rootBase0[PAGE_SHIFT-1:0],
                            rootBase1[VA_IN_W-1:PA_W], rootBase1[PAGE_SHIFT-1:0]};

  // per-level index slices and leaf address splices
  logic [IDX_W-1:0] idxAt   [LEVELS];
  logic [PA_W-1:0]  paddrAt [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : gLevel
    localparam int REM = VA_W - IDX_W * (g + 1);
    assign idxAt[g]   = vaReg[VA_W-1-IDX_W*g -: IDX_W];
    assign paddrAt[g] = {memRspData[PA_W-1:REM], vaReg[REM-1:0]};
  end

  assign memReqAddr = {baseReg, idxAt[levelReg], {ENTRY_SHIFT{1'b0}}};

  // descriptor classification for the current level
  logic [1:0] typeBits;
  logic       accessFlag, atFirst, atLast;
  assign typeBits   = memRspData[1:0];
  assign accessFlag = memRspData[AF_BIT];
  assign atFirst    = (levelReg == '0);
  assign atLast     = (levelReg == LAST_LVL);

  always_comb begin
    rspKind = DK_BAD;
    if (typeBits == 2'b11) begin
      if (atLast) rspKind = accessFlag ? DK_LEAF : DK_NOAF;
      else        rspKind = DK_NEXT;
    end else if (typeBits == 2'b01 && !atFirst && !atLast) begin
      rspKind = accessFlag ? DK_LEAF : DK_NOAF;
    end
  end

  // walk state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      accReg   <= ACC_FETCH;
      baseReg  <= '0;
      levelReg <= '0;
      restrReg <= '0;
    end else if (strobe.load) begin
      vaReg    <= reqVaddr[VA_W-1:0];
      accReg   <= reqAccess;
      baseReg  <= highRegion ? rootBase1[PA_W-1:PAGE_SHIFT] : rootBase0[PA_W-1:PAGE_SHIFT];
      levelReg <= '0;
      restrReg <= '0;
    end else if (strobe.advance) begin
      baseReg  <= memRspData[PA_W-1:PAGE_SHIFT];
      levelReg <= levelReg + 1'b1;
      restrReg <= restrReg | tableRestrict(memRspData[DESC_W-1 -: 5]);
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultType   <= EXC_NONE;
      faultCause  <= '0;
      faultStatus <= '0;
      resPaddr    <= '0;
      resRestrict <= '0;
      resDesc     <= '0;
    end else if (strobe.leafHit) begin
      faultType   <= EXC_NONE;
      faultCause  <= '0;
      resPaddr    <= paddrAt[levelReg];
      resRestrict <= restrReg;
      resDesc     <= memRspData;
    end else if (strobe.descFault) begin
      faultType   <= excFor(accReg);
      faultCause  <= causeFor(accReg, rspKind == DK_NOAF);
      faultStatus <= {{(STATUS_W-LVL_W){1'b0}}, levelReg};
      resPaddr    <= '0;
      resRestrict <= '0;
      resDesc     <= '0;
    end else if (strobe.rootFault) begin
      faultType   <= excFor(reqAccess);
      faultCause  <= causeFor(reqAccess, 1'b0);
      resPaddr    <= '0;
      resRestrict <= '0;
      resDesc     <= '0;
    end
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        regionOk,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  descKind_e   rspKind,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReqValid,
  output logic        doneValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walkState_e;

  walkState_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          if (regionOk) begin
            nextState = ST_ISSUE;
          end else begin
            strobe.rootFault = 1'b1;
            nextState        = ST_DONE;
          end
        end
      end
      ST_ISSUE: begin
        if (memReqReady) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          unique case (rspKind)
            DK_NEXT: begin
              strobe.advance = 1'b1;
              nextState      = ST_ISSUE;
            end
            DK_LEAF: begin
              strobe.leafHit = 1'b1;
              nextState      = ST_DONE;
            end
            default: begin
              strobe.descFault = 1'b1;
              nextState        = ST_DONE;
            end
          endcase
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign doneValid   = (state == ST_DONE);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_IN_W     = 64,
  parameter int VA_W        = 48,
  parameter int PA_W        = 48,
  parameter int IDX_W       = 9,
  parameter int LEVELS      = 4,
  parameter int PAGE_SHIFT  = 12,
  parameter int DESC_W      = 64,
  parameter int REGION_BITS = 16,
  parameter int AF_BIT      = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [VA_IN_W-1:0]    rootBase0,
  input  logic [VA_IN_W-1:0]    rootBase1,
  input  logic                  reqValid,
  input  logic [VA_IN_W-1:0]    reqVaddr,
  input  logic [1:0]            reqAccess,
  output logic                  busy,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [PA_W-1:0]       memReqAddr,
  input  logic                  memRspValid,
  input  logic [DESC_W-1:0]     memRspData,
  output logic                  doneValid,
  output logic [1:0]            faultType,
  output logic [7:0]            faultCause,
  output logic [STATUS_W-1:0]   faultStatus,
  output logic [PA_W-1:0]       resPaddr,
  output logic [RESTRICT_W-1:0] resRestrict,
  output logic [DESC_W-1:0]     resDesc
);

  walkStrobe_t strobe;
  logic        regionOk;
  descKind_e   rspKind;

  pt_walk_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .regionOk   (regionOk),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspKind    (rspKind),
    .strobe     (strobe),
    .busy       (busy),
    .memReqValid(memReqValid),
    .doneValid  (doneValid)
  );

  pt_walk_dp #(
    .VA_IN_W    (VA_IN_W),
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .IDX_W      (IDX_W),
    .LEVELS     (LEVELS),
    .PAGE_SHIFT (PAGE_SHIFT),
    .DESC_W     (DESC_W),
    .REGION_BITS(REGION_BITS),
    .AF_BIT     (AF_BIT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .rootBase0  (rootBase0),
    .rootBase1  (rootBase1),
    .memRspData (memRspData),
    .regionOk   (regionOk),
    .rspKind    (rspKind),
    .memReqAddr (memReqAddr),
    .faultType  (faultType),
    .faultCause (faultCause),
    .faultStatus(faultStatus),
    .resPaddr   (resPaddr),
    .resRestrict(resRestrict),
    .resDesc    (resDesc)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
#(
  parameter int VA_IN_W     = 64,
  parameter int PA_W        = 48,
  parameter int PAGE_SHIFT  = 12,
  parameter int REGION_BITS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [VA_IN_W-1:0]  rootBase0,
  input logic                reqValid,
  input logic [VA_IN_W-1:0]  reqVaddr,
  input logic                busy,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic [PA_W-1:0]     memReqAddr,
  input logic                doneValid,
  input logic [1:0]          faultType,
  input logic [7:0]          faultCause,
  input logic [STATUS_W-1:0] faultStatus
);

  logic [REGION_BITS-1:0] top;
  logic topZero, topOk;
  assign top     = reqVaddr[VA_IN_W-1 -: REGION_BITS];
  assign topZero = (top == '0);
  assign topOk   = topZero || (&top);

  a_r1_lower_root: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && topZero) |=>
      (memReqValid && memReqAddr[PA_W-1:PAGE_SHIFT] == rootBase0[PA_W-1:PAGE_SHIFT]));

  a_r2_region_fault: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !topOk) |=> (doneValid && !memReqValid && faultType != EXC_NONE));

  a_r4_status_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(faultStatus) |-> (doneValid && faultType != EXC_NONE));

  a_r6_noaf_is_fault: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && faultCause[4]) |-> (faultType != EXC_NONE));

  a_r7_clean_success: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && faultType == EXC_NONE) |-> (faultCause == 8'd0));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && !busy));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !doneValid));

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

endmodule

bind pt_walker pt_walker_chk #(
  .VA_IN_W    (VA_IN_W),
  .PA_W       (PA_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .REGION_BITS(REGION_BITS)
) chk (.*);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  import ptw_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [63:0] rootBase0, rootBase1;
  logic        reqValid;
  logic [63:0] reqVaddr;
  logic [1:0]  reqAccess;
  logic        busy, memReqValid;
  logic        memReqReady = 1'b0;
  logic [47:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = 64'd0;
  logic        doneValid;
  logic [1:0]  faultType;
  logic [7:0]  faultCause;
  logic [2:0]  faultStatus;
  logic [47:0] resPaddr;
  logic [4:0]  resRestrict;
  logic [63:0] resDesc;

  pt_walker uut (.*);

  localparam logic [47:0] ROOT0 = 48'h0000_0001_0000;
  localparam logic [47:0] ROOT1 = 48'h0000_0002_0000;

  logic [63:0] memArr [logic [47:0]];
  logic [47:0] addrHist [$];
  int          totDones = 0;
  logic        stallMode = 1'b0;

  // memory model
  always @(posedge clk) begin
    memReqReady <= stallMode ? ~memReqReady : 1'b1;
    memRspValid <= memReqValid && memReqReady;
    if (memReqValid && memReqReady) begin
      memRspData <= memArr.exists(memReqAddr) ? memArr[memReqAddr] : 64'd0;
      addrHist.push_back(memReqAddr);
    end
    if (doneValid) totDones++;
  end

  int checks = 0;
  int errors = 0;

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] tblBase(int l, bit hi);
    if (l == 0) return hi ? ROOT1 : ROOT0;
    return 48'h0010_0000 * l + (hi ? 48'h0800_0000 : 48'h0);
  endfunction

  function automatic logic [8:0] idxOf(logic [63:0] va, int l);
    return 9'((va[47:0] >> (39 - 9 * l)) & 48'h1ff);
  endfunction

  function automatic logic [47:0] descAddr(logic [63:0] va, int l, bit hi);
    return tblBase(l, hi) + (48'(idxOf(va, l)) << 3);
  endfunction

  // attrs: 5 bits per level, level 0 in bits 4:0
  task automatic buildTables(input logic [63:0] va, input bit hi, input int upto,
                             input logic [14:0] attrs);
    for (int l = 0; l < upto; l++) begin
      logic [47:0] nb;
      nb = tblBase(l + 1, hi);
      memArr[descAddr(va, l, hi)] = {attrs[5*l +: 5], 11'd0, nb[47:12], 10'd0, 2'b11};
    end
  endtask

  function automatic logic [63:0] leafDesc(logic [47:0] pa, logic af, logic [1:0] typ);
    return {16'd0, pa[47:12], 1'b0, af, 8'd0, typ};
  endfunction

  function automatic logic [4:0] expRestr(logic [4:0] a);
    logic [4:0] r;
    r = {(a[3:2] == 2'd1), (a[3:2] == 2'd2), (a[3:2] == 2'd3), a[1], a[0]};
    return r;
  endfunction

  function automatic logic [47:0] expPaddr(logic [63:0] d, logic [63:0] va, int lvl);
    int rem;
    logic [47:0] mask;
    rem  = 48 - 9 * (lvl + 1);
    mask = (48'h1 << rem) - 48'h1;
    return (d[47:0] & ~mask) | (va[47:0] & mask);
  endfunction

  function automatic logic [1:0] expExc(logic [1:0] acc);
    return (acc == 2'd0) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [7:0] accCause(logic [1:0] acc);
    return (acc == 2'd0) ? 8'h00 : {6'd0, acc};
  endfunction

  // captured results
  logic [1:0]  rType;
  logic [7:0]  rCause;
  logic [2:0]  rStatus;
  logic [47:0] rPaddr, rFirst, rLast;
  logic [4:0]  rRestr;
  logic [63:0] rDesc;
  int          rReads, rDones;

  task automatic doWalk(input logic [63:0] va, input logic [1:0] acc);
    int r0, d0;
    r0 = addrHist.size();
    d0 = totDones;
    @(negedge clk);
    reqVaddr  = va;
    reqAccess = acc;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 400 && !doneValid; n++) @(negedge clk);
    rType   = faultType;
    rCause  = faultCause;
    rStatus = faultStatus;
    rPaddr  = resPaddr;
    rRestr  = resRestrict;
    rDesc   = resDesc;
    @(negedge clk);
    rReads = addrHist.size() - r0;
    rDones = totDones - d0;
    rFirst = (rReads > 0) ? addrHist[r0] : 48'hx;
    rLast  = (rReads > 0) ? addrHist[addrHist.size() - 1] : 48'hx;
  endtask

  localparam logic [63:0] VA_LO   = 64'h0000_5A3C_9E71_2468;
  localparam logic [63:0] VA_HI   = 64'hFFFF_A5C3_61E8_DB97;
  localparam logic [63:0] VA_MIX1 = 64'h00F0_1234_5678_9ABC;
  localparam logic [63:0] VA_MIX2 = 64'h8000_0000_0000_0000;

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    logic [63:0] va, d;
    logic [47:0] pa;
    logic [2:0]  prevStatus;
    int          r0, d0;
    rstN      = 1'b0;
    rootBase0 = {16'hBEEF, ROOT0[47:12], 12'hABC};
    rootBase1 = {16'h1234, ROOT1[47:12], 12'h5A5};
    reqValid  = 1'b0;
    reqVaddr  = '0;
    reqAccess = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chkEq("R12 busy", busy, 0);
    chkEq("R12 memReqValid", memReqValid, 0);
    chkEq("R12 doneValid", doneValid, 0);
    chkEq("R12 faultType", faultType, 0);
    chkEq("R12 faultStatus", faultStatus, 0);

    // R1 R3 R5 R7 R10: successful walks, every leaf level, both halves, all accesses
    for (int hi = 0; hi < 2; hi++) begin
      for (int lvl = 1; lvl < 4; lvl++) begin
        for (int acc = 0; acc < 3; acc++) begin
          va = hi ? VA_HI : VA_LO;
          pa = 48'hC3A5_96F0_0000 ^ (48'(lvl) << 33) ^ (48'(acc) << 24);
          d  = leafDesc(pa, 1'b1, (lvl == 3) ? 2'b11 : 2'b01);
          memArr.delete();
          buildTables(va, hi[0], lvl, 15'd0);
          memArr[descAddr(va, lvl, hi[0])] = d;
          doWalk(va, 2'(acc));
          chkEq("R7 faultType", rType, 0);
          chkEq("R7 faultCause", rCause, 0);
          chkEq("R7 resPaddr", rPaddr, expPaddr(d, va, lvl));
          chkEq("R7 resDesc", rDesc, d);
          chkEq("R8 no restriction", rRestr, 0);
          chkEq("R5 read count", rReads, lvl + 1);
          chkEq("R1 root address", rFirst, descAddr(va, 0, hi[0]));
          chkEq("R3 leaf address", rLast, descAddr(va, lvl, hi[0]));
          chkEq("R10 one done", rDones, 1);
        end
      end
    end

    // R8 restriction accumulation over two table levels
    for (int a = 0; a < 32; a++) begin
      logic [4:0] b;
      b  = 5'((a * 7 + 3) % 32);
      pa = 48'h7654_3210_F000;
      d  = leafDesc(pa, 1'b1, 2'b11);
      memArr.delete();
      buildTables(VA_LO, 1'b0, 3, {5'd0, b, 5'(a)});
      memArr[descAddr(VA_LO, 3, 1'b0)] = d;
      doWalk(VA_LO, 2'd1);
      chkEq("R8 resRestrict", rRestr, expRestr(5'(a)) | expRestr(b));
      chkEq("R7 resPaddr with attrs", rPaddr, expPaddr(d, VA_LO, 3));
    end

    // R4 R9 invalid (zero) descriptor at each level
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int acc = 0; acc < 3; acc++) begin
        memArr.delete();
        buildTables(VA_LO, 1'b0, lvl, 15'd0);
        doWalk(VA_LO, 2'(acc));
        chkEq("R9 fault kind", rType, expExc(2'(acc)));
        chkEq("R4 cause", rCause, accCause(2'(acc)));
        chkEq("R4 status level", rStatus, 3'(lvl));
        chkEq("R4 reads", rReads, lvl + 1);
      end
    end

    // R6 access flag clear
    for (int lvl = 1; lvl < 4; lvl++) begin
      for (int acc = 0; acc < 3; acc++) begin
        memArr.delete();
        buildTables(VA_HI, 1'b1, lvl, 15'd0);
        memArr[descAddr(VA_HI, lvl, 1'b1)] =
          leafDesc(48'h0ABC_DEF0_0000, 1'b0, (lvl == 3) ? 2'b11 : 2'b01);
        doWalk(VA_HI, 2'(acc));
        chkEq("R6 fault kind", rType, expExc(2'(acc)));
        chkEq("R6 cause", rCause, 8'h10 | accCause(2'(acc)));
        chkEq("R6 status level", rStatus, 3'(lvl));
      end
    end

    // R5 type codes that are invalid at their level
    memArr.delete();
    memArr[descAddr(VA_LO, 0, 1'b0)] = leafDesc(48'h1234_5000_0000, 1'b1, 2'b01);
    doWalk(VA_LO, 2'd2);
    chkEq("R5 level0 block fault", rType, 2'd2);
    chkEq("R5 level0 block status", rStatus, 3'd0);
    chkEq("R5 level0 block reads", rReads, 1);

    memArr.delete();
    buildTables(VA_LO, 1'b0, 3, 15'd0);
    memArr[descAddr(VA_LO, 3, 1'b0)] = leafDesc(48'h1234_5000_0000, 1'b1, 2'b01);
    doWalk(VA_LO, 2'd1);
    chkEq("R5 level3 block fault", rType, 2'd2);
    chkEq("R5 level3 block status", rStatus, 3'd3);

    memArr.delete();
    buildTables(VA_LO, 1'b0, 1, 15'd0);
    memArr[descAddr(VA_LO, 1, 1'b0)] = leafDesc(48'h1234_5000_0000, 1'b1, 2'b10);
    doWalk(VA_LO, 2'd0);
    chkEq("R5 code10 fault", rType, 2'd1);
    chkEq("R5 code10 cause", rCause, 8'h00);
    chkEq("R5 code10 status", rStatus, 3'd1);

    memArr.delete();
    buildTables(VA_LO, 1'b0, 2, 15'd0);
    memArr[descAddr(VA_LO, 2, 1'b0)] = leafDesc(48'h1234_5000_0000, 1'b1, 2'b10);
    doWalk(VA_LO, 2'd2);
    chkEq("R5 code10 L2 status", rStatus, 3'd2);
    prevStatus = rStatus;

    // R2 mixed region: no read, status untouched
    for (int acc = 0; acc < 3; acc++) begin
      doWalk(VA_MIX1, 2'(acc));
      chkEq("R2 fault kind", rType, expExc(2'(acc)));
      chkEq("R2 cause", rCause, accCause(2'(acc)));
      chkEq("R2 no reads", rReads, 0);
      chkEq("R2 status kept", rStatus, prevStatus);
      doWalk(VA_MIX2, 2'(acc));
      chkEq("R2 fault kind top bit", rType, expExc(2'(acc)));
      chkEq("R2 no reads top bit", rReads, 0);
    end

    // R10 requests while busy are ignored
    pa = 48'h0F0F_0F0F_F000;
    d  = leafDesc(pa, 1'b1, 2'b11);
    memArr.delete();
    buildTables(VA_LO, 1'b0, 3, 15'd0);
    memArr[descAddr(VA_LO, 3, 1'b0)] = d;
    r0 = addrHist.size();
    d0 = totDones;
    @(negedge clk);
    reqVaddr = VA_LO; reqAccess = 2'd1; reqValid = 1'b1;
    @(negedge clk);
    reqVaddr = VA_MIX1; reqAccess = 2'd2;
    chkEq("R10 busy after accept", busy, 1);
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 400 && !doneValid; n++) @(negedge clk);
    chkEq("R10 first walk result", resPaddr, expPaddr(d, VA_LO, 3));
    chkEq("R10 first walk ok", faultType, 0);
    repeat (10) @(negedge clk);
    chkEq("R10 single done", totDones - d0, 1);
    chkEq("R10 reads of one walk", addrHist.size() - r0, 4);
    chkEq("R10 idle after done", busy, 0);

    // R11 stalled memory acceptance
    stallMode = 1'b1;
    doWalk(VA_LO, 2'd1);
    stallMode = 1'b0;
    chkEq("R11 stalled paddr", rPaddr, expPaddr(d, VA_LO, 3));
    chkEq("R11 stalled reads", rReads, 4);
    chkEq("R11 stalled last address", rLast, descAddr(VA_LO, 3, 1'b0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule